// File: doc/BRIEF.md
# Receive Frame Padding Inserter

This block sits in the receive byte path ahead of the buffer writer of an Ethernet DMA. It adds zero to three filler bytes into each frame at a chosen byte position. Software can then place the padding so that a later header or payload lands on a word boundary in memory. The input and output are byte-wide valid/ready streams, each with an end-of-frame marker. All input and output bytes pass through a single output register.

Two configuration inputs set the padding: a slot number (`cfg_slot`, 0 to 31) and a pad count (`cfg_pad`, 0 to 3). A slot of 0 places the filler ahead of the first data byte. A slot of N places the filler after data byte N, with bytes numbered from 1. If the frame ends on or before byte N, the filler follows the last data byte and the end marker moves onto the final filler byte. Both settings are captured when the first byte of a frame is presented. Later changes have no effect on that frame.

The control state machine has five states:
- `ST_HEAD` waits for the first byte of a frame.
- `ST_COPY` passes data bytes that come before the slot.
- `ST_FILL` emits filler bytes in the middle of a frame.
- `ST_REST` passes the remaining data bytes.
- `ST_TRAIL` emits filler bytes after a frame that ended early.

The transitions are:
- HEAD to FILL (slot 0, first filler sent) or HEAD to REST (slot 0, one filler byte).
- HEAD to COPY (first byte taken, slot above 1), HEAD to FILL (first byte taken, slot 1), HEAD to REST (pad count 0).
- HEAD to TRAIL (single-byte frame with padding), and HEAD back to HEAD (single-byte frame, no padding).
- COPY to FILL (byte N taken, not last) and COPY to TRAIL (last byte taken).
- FILL to REST (final filler sent).
- REST to HEAD (last byte taken).
- TRAIL to HEAD (final filler sent, carrying the end marker).

Top module: `pad_inserter`

## Requirements
- R1: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: With slot 0 and pad count k>0, the first k output bytes of the frame are filler, followed by all data bytes.
- R3: With slot N>0 and a frame longer than N, the k filler bytes appear between data byte N and data byte N+1, counting from 1.
- R4: Pad count code k (2-bit field, value 0, 1, 2 or 3) adds exactly k bytes, and every filler byte has the value 0x00.
- R5: If a frame has N or fewer data bytes (slot N>0, k>0), the filler follows the last data byte; the end marker is on the final filler byte only.
- R6: The slot and pad count are captured with the first byte of a frame; changes on those inputs later in the frame do not alter its output.
- R7: While filler bytes are emitted, `in_ready` is 0. Every accepted input byte appears on the output once, in order.
- R8: A byte accepted at a clock edge is on the output, valid, from the next edge (one register stage). With pad count 0 the frame passes through unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output byte and end marker hold steady, and no input byte is accepted.
- R10: If input is offered while the output register is empty, `out_valid` is 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slot | input | SLOT_W (5) | Byte slot after which filler goes; 0 = before the first byte |
| cfg_pad | input | PAD_W (2) | Number of filler bytes, 0 to 3 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | DATA_W (8) | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | DATA_W (8) | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The bench builds the block with its defaults: a 5-bit slot, a 2-bit pad count and byte data. The full slot range is therefore in reach, up to slot 31 with a 40-byte frame, as are all four pad counts. Frames end before, at and after the slot, with slot 0 and slot 1 at the low end. Random output back-pressure exercises every state while it is stalled. The configuration inputs are scrambled after each first byte to show that they are captured once per frame.

// File: rtl/pad_inserter_pkg.sv
package pad_inserter_pkg;

    typedef enum logic [2:0] {
        ST_HEAD  = 3'd0,
        ST_COPY  = 3'd1,
        ST_FILL  = 3'd2,
        ST_REST  = 3'd3,
        ST_TRAIL = 3'd4
    } pad_state_e;

endpackage

// File: rtl/pad_out_stage.sv
module pad_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [DATA_W-1:0] emit_data,
    input  logic              emit_last,
    input  logic              out_ready,
    output logic              load_ok,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);

    assign load_ok = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load_ok) begin
            out_valid <= emit;
            if (emit) begin
                out_data <= emit_data;
                out_last <= emit_last;
            end
        end
    end

endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl
    import pad_inserter_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int PAD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [PAD_W-1:0]  cfg_pad,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              load_ok,
    output logic              in_ready,
    output logic              emit,
    output logic              emit_pad,
    output logic              emit_last
);

    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
    localparam logic [PAD_W-1:0]  PAD_ONE  = PAD_W'(1);

    pad_state_e        st_q, st_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [SLOT_W-1:0] cnt_q, cnt_d;
    logic [PAD_W-1:0]  left_q, left_d;
    logic              lead_fill;
    logic              take;
    logic [SLOT_W-1:0] cnt_inc;

    assign lead_fill = in_valid && (cfg_pad != '0) && (cfg_slot == '0);
    assign take      = in_valid && in_ready;
    assign cnt_inc   = cnt_q + SLOT_ONE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HEAD;
            slot_q <= '0;
            cnt_q  <= '0;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            slot_q <= slot_d;
            cnt_q  <= cnt_d;
            left_q <= left_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        slot_d = slot_q;
        cnt_d  = cnt_q;
        left_d = left_q;
        unique case (st_q)
            ST_HEAD: begin
                if (lead_fill && load_ok) begin
                    slot_d = cfg_slot;
                    left_d = cfg_pad - PAD_ONE;
                    st_d   = (cfg_pad == PAD_ONE) ? ST_REST : ST_FILL;
                end else if (take) begin
                    slot_d = cfg_slot;
                    cnt_d  = SLOT_ONE;
                    left_d = cfg_pad;
                    if (in_last)
                        st_d = (cfg_pad != '0) ? ST_TRAIL : ST_HEAD;
                    else if (cfg_pad == '0)
                        st_d = ST_REST;
                    else if (cfg_slot == SLOT_ONE)
                        st_d = ST_FILL;
                    else
                        st_d = ST_COPY;
                end
            end
            ST_COPY: begin
                if (take) begin
                    cnt_d = cnt_inc;
                    if (in_last)
                        st_d = ST_TRAIL;
                    else if (cnt_inc == slot_q)
                        st_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (load_ok) begin
                    left_d = left_q - PAD_ONE;
                    if (left_q == PAD_ONE)
                        st_d = ST_REST;
                end
            end
            ST_TRAIL: begin
                if (load_ok) begin
                    left_d = left_q - PAD_ONE;
                    if (left_q == PAD_ONE)
                        st_d = ST_HEAD;
                end
            end
            ST_REST: begin
                if (take && in_last)
                    st_d = ST_HEAD;
            end
            default: st_d = ST_HEAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        emit      = 1'b0;
        emit_pad  = 1'b0;
        emit_last = 1'b0;
        unique case (st_q)
            ST_HEAD: begin
                if (lead_fill) begin
                    emit     = load_ok;
                    emit_pad = 1'b1;
                end else begin
                    in_ready  = load_ok;
                    emit      = in_valid && load_ok;
                    emit_last = in_last && (cfg_pad == '0);
                end
            end
            ST_COPY: begin
                in_ready = load_ok;
                emit     = in_valid && load_ok;
            end
            ST_FILL: begin
                emit     = load_ok;
                emit_pad = 1'b1;
            end
            ST_TRAIL: begin
                emit      = load_ok;
                emit_pad  = 1'b1;
                emit_last = (left_q == PAD_ONE);
            end
            ST_REST: begin
                in_ready  = load_ok;
                emit      = in_valid && load_ok;
                emit_last = in_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pad_inserter.sv
module pad_inserter #(
    parameter int                 SLOT_W    = 5,
    parameter int                 PAD_W     = 2,
    parameter int                 DATA_W    = 8,
    parameter logic [DATA_W-1:0]  PAD_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [PAD_W-1:0]  cfg_pad,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);

    logic              load_ok;
    logic              emit;
    logic              emit_pad;
    logic              emit_last;
    logic [DATA_W-1:0] emit_data;

    assign emit_data = emit_pad ? PAD_VALUE : in_data;

    pad_ctrl #(
        .SLOT_W (SLOT_W),
        .PAD_W  (PAD_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_slot  (cfg_slot),
        .cfg_pad   (cfg_pad),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .load_ok   (load_ok),
        .in_ready  (in_ready),
        .emit      (emit),
        .emit_pad  (emit_pad),
        .emit_last (emit_last)
    );

    pad_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .emit_data (emit_data),
        .emit_last (emit_last),
        .out_ready (out_ready),
        .load_ok   (load_ok),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/pad_inserter_chk.sv
module pad_inserter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last
);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R10
    no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |=> out_valid);

endmodule

bind pad_inserter pad_inserter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/pad_inserter_bench.sv
module pad_inserter_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] cfg_slot;
    logic [1:0] cfg_pad;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       in_last;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_last;

    always #10 clk = ~clk;

    pad_inserter u_pad_inserter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_slot  (cfg_slot),
        .cfg_pad   (cfg_pad),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0] slot;
        logic [1:0] pad;
        logic [7:0] len;
        logic       stall;
        logic [7:0] olen;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  2'd0, 8'd6,  1'b0, 8'd6},
        '{5'd0,  2'd2, 8'd5,  1'b0, 8'd7},
        '{5'd3,  2'd1, 8'd8,  1'b1, 8'd9},
        '{5'd5,  2'd3, 8'd5,  1'b0, 8'd8},
        '{5'd7,  2'd2, 8'd4,  1'b1, 8'd6},
        '{5'd31, 2'd3, 8'd40, 1'b1, 8'd43},
        '{5'd1,  2'd3, 8'd1,  1'b0, 8'd4},
        '{5'd4,  2'd0, 8'd9,  1'b1, 8'd9},
        '{5'd0,  2'd3, 8'd1,  1'b1, 8'd4},
        '{5'd2,  2'd2, 8'd3,  1'b0, 8'd5},
        '{5'd31, 2'd1, 8'd31, 1'b0, 8'd32},
        '{5'd1,  2'd1, 8'd2,  1'b1, 8'd3}
    };

    logic [7:0] exp_d [64];
    logic       exp_l [64];
    int         exp_n;
    logic [7:0] got_d [64];
    logic       got_l [64];
    int         got_n;

    task automatic push_exp(input logic [7:0] d);
        exp_d[exp_n] = d;
        exp_l[exp_n] = 1'b0;
        exp_n++;
    endtask

    task automatic build_model(input int slot, input int pad, input int len, input int base);
        exp_n = 0;
        if (pad != 0 && slot == 0)
            for (int p = 0; p < pad; p++) push_exp(8'h00);
        for (int i = 1; i <= len; i++) begin
            push_exp(8'(base + i - 1));
            if (pad != 0 && slot != 0 && i == slot && i != len)
                for (int p = 0; p < pad; p++) push_exp(8'h00);
        end
        if (pad != 0 && slot != 0 && len <= slot)
            for (int p = 0; p < pad; p++) push_exp(8'h00);
        exp_l[exp_n-1] = 1'b1;
    endtask

    task automatic drive_frame(input logic [4:0] slot, input logic [1:0] pad,
                               input int len, input int base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cfg_slot = slot;
                cfg_pad  = pad;
            end
            in_valid = 1'b1;
            in_data  = 8'(base + i);
            in_last  = (i == len - 1);
            forever begin
                #2;
                if (in_ready) begin
                    @(posedge clk);
                    break;
                end
                @(negedge clk);
            end
            // R6: configuration inputs scrambled once the first byte is taken
            if (i == 0) begin
                #1;
                cfg_slot = slot ^ 5'h15;
                cfg_pad  = pad ^ 2'd1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(input bit stall);
        bit done;
        done  = 1'b0;
        got_n = 0;
        while (!done) begin
            @(negedge clk);
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                if (got_n < 64) begin
                    got_d[got_n] = out_data;
                    got_l[got_n] = out_last;
                end
                got_n++;
                if (out_last) done = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string tag;
        rst_n     = 1'b0;
        cfg_slot  = '0;
        cfg_pad   = '0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_last   = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        #2;
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

        for (int v = 0; v < NV; v++) begin
            int base;
            base = 16 * v + 1;
            build_model(VECS[v].slot, VECS[v].pad, VECS[v].len, base);
            if (VECS[v].pad == 0)
                tag = "R8";
            else if (VECS[v].slot == 0)
                tag = "R2";
            else if (VECS[v].len <= VECS[v].slot)
                tag = "R5";
            else
                tag = "R3";
            fork
                drive_frame(VECS[v].slot, VECS[v].pad, VECS[v].len, base);
                collect(VECS[v].stall);
            join
            check(got_n == VECS[v].olen, $sformatf("R4 frame %0d length", v), got_n, VECS[v].olen);
            check(got_n == exp_n, $sformatf("R4 frame %0d model length", v), got_n, exp_n);
            for (int b = 0; b < exp_n && b < got_n; b++) begin
                check(got_d[b] == exp_d[b],
                      $sformatf("%s R6 R7 frame %0d byte %0d data", tag, v, b), got_d[b], exp_d[b]);
                check(got_l[b] == exp_l[b],
                      $sformatf("%s R5 frame %0d byte %0d last", tag, v, b), got_l[b], exp_l[b]);
            end
        end

        // R8: single register stage with pad count 0
        @(negedge clk);
        cfg_slot  = 5'd3;
        cfg_pad   = 2'd0;
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = 8'hA5;
        in_last   = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(out_valid == 1'b1, "R8 valid one edge later", out_valid, 1);
        check(out_data == 8'hA5, "R8 data one edge later", out_data, 8'hA5);
        check(out_last == 1'b1, "R8 last passes through", out_last, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 drained", out_valid, 0);

        // R10, R2, R7: lead filler with empty output register
        cfg_slot = 5'd0;
        cfg_pad  = 2'd2;
        in_valid = 1'b1;
        in_data  = 8'h77;
        in_last  = 1'b1;
        #2;
        check(in_ready == 1'b0, "R7 ready low before lead filler", in_ready, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R10 valid after offered input", out_valid, 1);
        check(out_data == 8'h00, "R2 first filler", out_data, 0);
        check(in_ready == 1'b0, "R7 ready low during filler", in_ready, 0);
        @(negedge clk);
        check(out_data == 8'h00 && out_last == 1'b0, "R2 second filler", out_data, 0);
        check(in_ready == 1'b1, "R7 ready after filler", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(out_data == 8'h77 && out_last == 1'b1, "R2 data after filler", out_data, 8'h77);
        @(negedge clk);

        // R9: output held under back-pressure
        cfg_pad   = 2'd0;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 8'h3C;
        in_last   = 1'b1;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h99;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1 && out_data == 8'h3C, "R9 data held", out_data, 8'h3C);
        check(out_last == 1'b1, "R9 last held", out_last, 1);
        check(in_ready == 1'b0, "R9 no input taken while full", in_ready, 0);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 released", out_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule